// File: doc/BRIEF.md
# Byte-Wide Fetch and Load/Store Sequencer

This block is the control unit and memory-side register set of a small 8-bit machine. Instructions are 16 bits wide, but the memory port carries one byte per access. Each instruction is therefore fetched as two byte reads, low half first, and the two bytes are held in separate halves of the instruction register. The program counter is the last register of an internal register file. It is copied into the memory address register by ORing it with itself in the ALU. After each byte read it is advanced by a pass through the ALU with carry-in set.

After the fetch, the sequencer runs one of four instructions:
- load-immediate, which takes the literal from the low byte;
- add, between two registers;
- word load, through the data register;
- word store, through the data register.

Every memory read or write holds its strobe for as long as memory reports a wait. The sequencer rests in an idle state while `run` is low. It goes back to fetch after each instruction for as long as `run` stays high.

Top module: `byte_fetch_seq`

## Requirements
- R1: During reset and afterwards, while `run` is low: `mem_rd`, `mem_wr` and `busy_o` are 0, `mem_addr`, `mem_wdata` and `instr_o` are 0, and no memory access starts.
- R2: Fetch behaviour.
  - Each fetch reads the byte at the program counter (register 7), then the byte at the program counter plus one, modulo 256.
  - `instr_o` then holds {second byte, first byte].
  - The program counter advances by 2 per fetch.
- R3: Wait handling for reads and writes.
  - While `mem_wait` is high during an access, the strobe stays high and `mem_addr` (and `mem_wdata` for a write) stays unchanged.
  - Read data is taken only on the first cycle in which `mem_wait` is low.
- R4: Instruction word encoding.
  - Bits [15:14] hold the opcode: 00 load-immediate, 01 load, 10 store, 11 add.
  - Bits [13:11] name rd, bits [10:8] name ra and bits [7:5] name rb.
  - Load-immediate writes bits [7:0] into rd.
- R5: A load reads the byte at address r[ra] and writes it into rd.
- R6: A store writes r[rd] to address r[ra], using one write access.
- R7: An add writes (r[ra] + r[rb]) mod 256 into rd. Register 7 read as a source gives the already-advanced program counter.
- R8: Instruction timing.
  - With no wait cycles, load-immediate and add take 7 clock cycles from one fetch to the next. Load and store take 9.
  - Every wait cycle adds exactly one cycle.
- R9: After the last access of an instruction, the next fetch begins if `run` is high. Otherwise the block returns to idle with `busy_o` low and no strobes.
- R10: A load or load-immediate into register 7 redirects the next fetch to the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Keep fetching while high |
| mem_rdata | input | 8 | Read data from memory |
| mem_wait | input | 1 | Memory not ready; current access must be held |
| mem_addr | output | 8 | Memory address register |
| mem_wdata | output | 8 | Memory data register |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| instr_o | output | 16 | Assembled instruction register |
| busy_o | output | 1 | High whenever the sequencer is not idle |

## Verification
During every wait cycle, the bench drives junk values onto `mem_rdata`. A design that captured its read data before the wait dropped would therefore load the wrong fetch byte or the wrong load result. Wait lengths vary from access to access. The gap between access completions is checked, so a strobe that dropped early or an extra state in the sequence shows up as a cycle-count error. The program includes an add that wraps past 255. It also includes a load into the program counter, which a design that keeps a private program counter would ignore, and a store of register 7 after the jump, which exposes a program counter advanced at the wrong moment.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_F0_MAR, S_F0_RD, S_F0_INC, S_F1_MAR, S_F1_RD, S_F1_INC,
    S_EXEC, S_LD_RD, S_LD_WB, S_ST_MDR, S_ST_WR
  } seq_state_e;

  typedef enum logic [1:0] {ALU_OR = 2'd0, ALU_ADDA = 2'd1, ALU_ADD = 2'd2} alu_op_e;

  typedef enum logic [1:0] {RES_ALU = 2'd0, RES_MDR = 2'd1, RES_HI = 2'd2, RES_LIT = 2'd3} res_sel_e;

  typedef enum logic [1:0] {MDR_HOLD = 2'd0, MDR_ALU = 2'd1, MDR_MEM = 2'd2} mdr_sel_e;

  typedef enum logic [1:0] {OP_LI = 2'd0, OP_LW = 2'd1, OP_SW = 2'd2, OP_ADD = 2'd3} opcode_e;

endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
  import seqctl_pkg::*;
#(
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           mem_wait,
  input  opcode_e        op,
  input  logic [RAW-1:0] f_rd,
  input  logic [RAW-1:0] f_ra,
  input  logic [RAW-1:0] f_rb,
  output logic [RAW-1:0] a_sel,
  output logic [RAW-1:0] b_sel,
  output alu_op_e        alu_op,
  output logic           cin,
  output res_sel_e       res_sel,
  output logic           rf_we,
  output logic [RAW-1:0] rf_wsel,
  output logic           mar_ld,
  output mdr_sel_e       mdr_sel,
  output logic           ir0_ld,
  output logic           ir1_ld,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           busy
);
  localparam logic [RAW-1:0] PC_IDX = RAW'(NREG - 1);

  seq_state_e state_q, state_d;
  seq_state_e after_instr;

  assign after_instr = run ? S_F0_MAR : S_IDLE;
  assign busy = (state_q != S_IDLE);

  always_comb begin
    state_d = state_q;
    a_sel   = '0;
    b_sel   = '0;
    alu_op  = ALU_OR;
    cin     = 1'b0;
    res_sel = RES_ALU;
    rf_we   = 1'b0;
    rf_wsel = '0;
    mar_ld  = 1'b0;
    mdr_sel = MDR_HOLD;
    ir0_ld  = 1'b0;
    ir1_ld  = 1'b0;
    mem_rd  = 1'b0;
    mem_wr  = 1'b0;
    unique case (state_q)
      S_IDLE: if (run) state_d = S_F0_MAR;
      S_F0_MAR, S_F1_MAR: begin
        a_sel   = PC_IDX;
        b_sel   = PC_IDX;
        mar_ld  = 1'b1;
        state_d = (state_q == S_F0_MAR) ? S_F0_RD : S_F1_RD;
      end
      S_F0_RD: begin
        mem_rd = 1'b1;
        ir0_ld = !mem_wait;
        if (!mem_wait) state_d = S_F0_INC;
      end
      S_F1_RD: begin
        mem_rd = 1'b1;
        ir1_ld = !mem_wait;
        if (!mem_wait) state_d = S_F1_INC;
      end
      S_F0_INC, S_F1_INC: begin
        a_sel   = PC_IDX;
        alu_op  = ALU_ADDA;
        cin     = 1'b1;
        rf_we   = 1'b1;
        rf_wsel = PC_IDX;
        state_d = (state_q == S_F0_INC) ? S_F1_MAR : S_EXEC;
      end
      S_EXEC: begin
        unique case (op)
          OP_LI: begin
            res_sel = RES_LIT;
            rf_we   = 1'b1;
            rf_wsel = f_rd;
            state_d = after_instr;
          end
          OP_ADD: begin
            a_sel   = f_ra;
            b_sel   = f_rb;
            alu_op  = ALU_ADD;
            rf_we   = 1'b1;
            rf_wsel = f_rd;
            state_d = after_instr;
          end
          default: begin
            a_sel   = f_ra;
            b_sel   = f_ra;
            mar_ld  = 1'b1;
            state_d = (op == OP_LW) ? S_LD_RD : S_ST_MDR;
          end
        endcase
      end
      S_LD_RD: begin
        mem_rd  = 1'b1;
        mdr_sel = mem_wait ? MDR_HOLD : MDR_MEM;
        if (!mem_wait) state_d = S_LD_WB;
      end
      S_LD_WB: begin
        res_sel = RES_MDR;
        rf_we   = 1'b1;
        rf_wsel = f_rd;
        state_d = after_instr;
      end
      S_ST_MDR: begin
        a_sel   = f_rd;
        b_sel   = f_rd;
        mdr_sel = MDR_ALU;
        state_d = S_ST_WR;
      end
      S_ST_WR: begin
        mem_wr = 1'b1;
        if (!mem_wait) state_d = after_instr;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> (!mem_rd && !mem_wr && !mar_ld));

  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir1_ld |-> $past(state_q) != S_IDLE);

endmodule

// File: rtl/mem_dp.sv
module mem_dp
  import seqctl_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG),
  localparam int IW  = 2 * DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RAW-1:0] a_sel,
  input  logic [RAW-1:0] b_sel,
  input  alu_op_e        alu_op,
  input  logic           cin,
  input  res_sel_e       res_sel,
  input  logic           rf_we,
  input  logic [RAW-1:0] rf_wsel,
  input  logic           mar_ld,
  input  mdr_sel_e       mdr_sel,
  input  logic           ir0_ld,
  input  logic           ir1_ld,
  input  logic [DW-1:0]  mem_rdata,
  output logic [DW-1:0]  mar_q,
  output logic [DW-1:0]  mdr_q,
  output logic [IW-1:0]  ir_q
);
  function automatic logic [DW-1:0] alu_eval(alu_op_e f, logic [DW-1:0] a,
                                             logic [DW-1:0] b, logic c);
    logic [DW-1:0] cw;
    cw = {{(DW-1){1'b0}}, c};
    unique case (f)
      ALU_OR:   return a | b;
      ALU_ADDA: return a + cw;
      ALU_ADD:  return a + b + cw;
      default:  return a;
    endcase
  endfunction

  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] bus_a, bus_b, alu_y, result;

  assign bus_a = rf[a_sel];
  assign bus_b = rf[b_sel];
  assign alu_y = alu_eval(alu_op, bus_a, bus_b, cin);

  always_comb begin
    unique case (res_sel)
      RES_MDR: result = mdr_q;
      RES_HI:  result = ir_q[IW-1:DW];
      RES_LIT: result = ir_q[DW-1:0];
      default: result = alu_y;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (rf_we) rf[rf_wsel] <= result;
      if (mar_ld) mar_q <= alu_y;
      unique case (mdr_sel)
        MDR_ALU: mdr_q <= alu_y;
        MDR_MEM: mdr_q <= mem_rdata;
        default: mdr_q <= mdr_q;
      endcase
      if (ir0_ld) ir_q[DW-1:0]  <= mem_rdata;
      if (ir1_ld) ir_q[IW-1:DW] <= mem_rdata;
    end
  end

  // R3
  ir_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir0_ld |=> ir_q[DW-1:0] == $past(mem_rdata));

  // R5
  mdr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdr_sel == MDR_MEM) |=> mdr_q == $past(mem_rdata));

endmodule

// File: rtl/byte_fetch_seq.sv
module byte_fetch_seq
  import seqctl_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG),
  localparam int IW  = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_wait,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [IW-1:0] instr_o,
  output logic          busy_o
);
  logic [RAW-1:0] a_sel, b_sel, rf_wsel;
  alu_op_e        alu_op;
  res_sel_e       res_sel;
  mdr_sel_e       mdr_sel;
  logic           cin, rf_we, mar_ld, ir0_ld, ir1_ld;
  logic [IW-1:0]  ir_q;
  opcode_e        op;
  logic [RAW-1:0] f_rd, f_ra, f_rb;

  assign op   = opcode_e'(ir_q[IW-1 -: 2]);
  assign f_rd = ir_q[IW-3 -: RAW];
  assign f_ra = ir_q[IW-3-RAW -: RAW];
  assign f_rb = ir_q[DW-1 -: RAW];
  assign instr_o = ir_q;

  seq_fsm #(.NREG(NREG)) fsm_i (
    .clk(clk), .rst_n(rst_n), .run(run), .mem_wait(mem_wait),
    .op(op), .f_rd(f_rd), .f_ra(f_ra), .f_rb(f_rb),
    .a_sel(a_sel), .b_sel(b_sel), .alu_op(alu_op), .cin(cin),
    .res_sel(res_sel), .rf_we(rf_we), .rf_wsel(rf_wsel), .mar_ld(mar_ld),
    .mdr_sel(mdr_sel), .ir0_ld(ir0_ld), .ir1_ld(ir1_ld),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy_o)
  );

  mem_dp #(.DW(DW), .NREG(NREG)) dp_i (
    .clk(clk), .rst_n(rst_n), .a_sel(a_sel), .b_sel(b_sel),
    .alu_op(alu_op), .cin(cin), .res_sel(res_sel), .rf_we(rf_we),
    .rf_wsel(rf_wsel), .mar_ld(mar_ld), .mdr_sel(mdr_sel),
    .ir0_ld(ir0_ld), .ir1_ld(ir1_ld), .mem_rdata(mem_rdata),
    .mar_q(mem_addr), .mdr_q(mem_wdata), .ir_q(ir_q)
  );

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_wait) |=> (mem_rd && $stable(mem_addr)));

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_wait) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R9
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_rd && !mem_wr));

endmodule

// File: tb/byte_fetch_seq_tb_top.sv
module byte_fetch_seq_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, run = 1'b0, mem_wait = 1'b0;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  mem_addr, mem_wdata;
  logic        mem_rd, mem_wr, busy_o;
  logic [15:0] instr_o;

  byte_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .mem_rdata(mem_rdata),
    .mem_wait(mem_wait), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .instr_o(instr_o), .busy_o(busy_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int dmem [256];
  int imem [256];
  int regs [8];
  int q_kind[$], q_addr[$], q_data[$], q_gap[$], q_ir[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int enc(int op, int rd, int ra, int low);
    return (op << 14) | (rd << 11) | (ra << 8) | (low & 255);
  endfunction

  task automatic put(int addr, int w);
    dmem[addr] = w & 255;
    dmem[addr + 1] = (w >> 8) & 255;
  endtask

  // Instruction-level reference: fills the expected access queues
  task automatic build_expect(int n);
    int pc = 0, prev = -1;
    for (int i = 0; i < 8; i++) regs[i] = 0;
    for (int i = 0; i < n; i++) begin
      int w, op, rd, ra, rb;
      w = imem[pc] | (imem[(pc + 1) & 255] << 8);
      q_kind.push_back(0); q_addr.push_back(pc); q_data.push_back(imem[pc]);
      q_gap.push_back(prev < 0 ? -1 : (prev == 1 ? 3 : (prev == 2 ? 2 : 4)));
      q_kind.push_back(1); q_addr.push_back((pc + 1) & 255);
      q_data.push_back(imem[(pc + 1) & 255]); q_gap.push_back(3);
      q_ir.push_back(w);
      regs[7] = (pc + 2) & 255;
      op = (w >> 14) & 3; rd = (w >> 11) & 7; ra = (w >> 8) & 7; rb = (w >> 5) & 7;
      case (op)
        0: regs[rd] = w & 255;
        3: regs[rd] = (regs[ra] + regs[rb]) & 255;
        1: begin
          q_kind.push_back(2); q_addr.push_back(regs[ra]);
          q_data.push_back(imem[regs[ra]]); q_gap.push_back(3);
          regs[rd] = imem[regs[ra]];
        end
        default: begin
          q_kind.push_back(3); q_addr.push_back(regs[ra]);
          q_data.push_back(regs[rd]); q_gap.push_back(4);
          imem[regs[ra]] = regs[rd];
        end
      endcase
      pc = regs[7];
      prev = op;
    end
  endtask

  initial begin
    int wait_tgt = 0, wait_cnt = 0, acc_idx = 0, last_cyc = -1;
    int exp_ir = 0;
    bit ir_pending = 0, timeout = 0;

    for (int i = 0; i < 256; i++) dmem[i] = (i * 7 + 3) & 255;
    put(0,  enc(0, 0, 0, 110));      // LI  r0,110
    put(2,  enc(1, 1, 0, 0));        // LW  r1,[r0]
    put(4,  enc(0, 2, 0, 7));        // LI  r2,7
    put(6,  enc(3, 3, 1, 2 << 5));   // ADD r3,r1,r2
    put(8,  enc(0, 0, 0, 120));      // LI  r0,120
    put(10, enc(2, 3, 0, 0));        // SW  r3,[r0]
    put(12, enc(0, 5, 0, 255));      // LI  r5,255
    put(14, enc(3, 6, 5, 5 << 5));   // ADD r6,r5,r5 (wraps)
    put(16, enc(0, 0, 0, 121));      // LI  r0,121
    put(18, enc(2, 6, 0, 0));        // SW  r6,[r0]
    put(20, enc(0, 0, 0, 130));      // LI  r0,130
    put(22, enc(1, 7, 0, 0));        // LW  r7,[r0] -> jump
    put(60, enc(0, 0, 0, 122));      // LI  r0,122
    put(62, enc(2, 7, 0, 0));        // SW  r7,[r0]
    put(64, enc(1, 4, 0, 0));        // LW  r4,[r0]
    put(66, enc(0, 0, 0, 123));      // LI  r0,123
    put(68, enc(2, 4, 0, 0));        // SW  r4,[r0]
    dmem[110] = 35;
    dmem[130] = 60;
    for (int i = 0; i < 256; i++) imem[i] = dmem[i];
    build_expect(17);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!mem_rd && !mem_wr && !busy_o, "R1", "strobes/busy in reset",
        {mem_rd, mem_wr, busy_o}, 0);
    chk(mem_addr == 0 && mem_wdata == 0, "R1", "addr/wdata in reset",
        {mem_addr, mem_wdata}, 0);
    chk(instr_o == 0, "R1", "instr in reset", instr_o, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!mem_rd && !mem_wr && !busy_o, "R1", "idle with run low",
          {mem_rd, mem_wr, busy_o}, 0);
    end

    run = 1'b1;
    while (q_kind.size() > 0 && !timeout) begin
      @(negedge clk);
      if (ir_pending) begin
        chk(instr_o == exp_ir[15:0], "R2", "assembled instruction", instr_o, exp_ir);
        ir_pending = 0;
      end
      if (mem_rd || mem_wr) begin
        if (wait_cnt < wait_tgt) begin
          mem_wait = 1'b1;
          mem_rdata = 8'hE0 ^ 8'(wait_cnt);   // junk: must not be captured (R3)
          wait_cnt++;
        end else begin
          int k, a, d, g;
          k = q_kind.pop_front(); a = q_addr.pop_front();
          d = q_data.pop_front(); g = q_gap.pop_front();
          mem_wait = 1'b0;
          if (k == 3) begin
            chk(mem_wr && !mem_rd, "R6", "write strobe expected", mem_wr, 1);
            chk(int'(mem_addr) == a, "R6", "store address", mem_addr, a);
            chk(int'(mem_wdata) == d, "R4 R6 R7", "store data", mem_wdata, d);
            dmem[mem_addr] = mem_wdata;
          end else begin
            chk(mem_rd && !mem_wr, k == 2 ? "R5" : "R2", "read strobe expected", mem_rd, 1);
            chk(int'(mem_addr) == a, k == 2 ? "R5" : "R2 R10", "read address", mem_addr, a);
            mem_rdata = 8'(dmem[mem_addr]);
          end
          if (g >= 0)
            chk(cyc - last_cyc == g + wait_tgt, "R8", "cycles between accesses",
                cyc - last_cyc, g + wait_tgt);
          last_cyc = cyc;
          if (k == 1) begin
            ir_pending = 1;
            exp_ir = q_ir.pop_front();
          end
          acc_idx++;
          wait_tgt = (acc_idx * 3) % 5;
          wait_cnt = 0;
          if (q_kind.size() == 0) run = 1'b0;
        end
      end else begin
        mem_wait = 1'b0;
      end
      if (cyc > 20000) begin
        timeout = 1;
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog: actual %0d cycles expected completion", cyc);
      end
    end

    // R9: back to idle once run is dropped
    repeat (2) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!mem_rd && !mem_wr && !busy_o, "R9", "idle after run dropped",
          {mem_rd, mem_wr, busy_o}, 0);
    end
    chk(dmem[120] == 42,  "R5 R7", "r1+r2 stored", dmem[120], 42);
    chk(dmem[121] == 254, "R7", "wrapped sum stored", dmem[121], 254);
    chk(dmem[122] == 64,  "R10", "pc after jump", dmem[122], 64);
    chk(dmem[123] == 64,  "R4 R5", "reloaded value", dmem[123], 64);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule